// File: doc/BRIEF.md
# DMA Request Masking and Arbitration Front End

This block sits in front of a two-channel DMA engine that shares the system bus with one external bus master. It gathers the channel request pins and the software-issued requests, applies masking per channel and for both channels together, and samples the request and end-of-process pins in one of two timing modes. It then picks one of three requesters (channel 0, channel 1, the external master) and grants the bus to that one alone. A granted requester keeps the bus until it drops its request.

Software controls the block through a small register port. Each write takes effect on the clock edge where `reg_wr_i` is high. Read data is combinational from `reg_addr_i` while `reg_rd_i` is high. A status read also clears the latched terminal-count flags on that edge. Terminal-count strobes arrive from the transfer engine outside this block. There is no streaming data path, so every pin is a plain control or status signal.

Register offsets: 0 status, 1 software request, 2 channel mask, 3 group mask, 4 command. Unlisted offsets read as zero and ignore writes.

Top module: `dma_req_arbiter`

## Requirements
- R1: `gnt_o` is one-hot or zero. Bit 0 grants channel 0, bit 1 grants channel 1 and bit 2 grants the external master. After reset it is zero.
- R2: With no grant active, the next edge grants the highest-priority requester. The fixed order is channel 0, then channel 1, then the external master. Command bits [1:0] move one requester to the bottom: 0 selects channel 0, 1 selects channel 1, and 2 or 3 selects the external master. The other two keep their fixed order. `ext_req_i` is registered once, so it reaches `gnt_o` two edges after it is driven.
- R3: A grant stays unchanged while its requester keeps requesting, even if a higher-priority request appears. On the edge where the held requester is no longer requesting, a new arbitration runs among the remaining requests.
- R4: Channel mask register (offset 2) bits [1:0] block the hardware request of channel 0 and channel 1. The register resets to 2'b11 and reads back.
- R5: Group mask register (offset 3) bit 0 blocks the hardware requests of both channels at once. It resets to 0 and reads back.
- R6: Neither mask blocks a software request. A masked channel with a pending software request still wins arbitration.
- R7: Software request register (offset 1): writing 1 to bit n sets the pending request of channel n, and writing 0 has no effect. A read shows the pending bits. `tc_i[n]` clears bit n on the same edge and takes precedence over a write.
- R8: Status register (offset 0, read-only): bits [1:0] show the sampled, unmasked request pins. Bits [5:4] latch the `tc_i` strobes of channels 0 and 1. A status read clears bits [5:4] on its edge, unless a strobe arrives on that same edge.
- R9: Command bit 4 selects the pin sampling mode. With 0 (synchronous), `dreq_i` and `eop_n_i` pass one register, so a `dreq_i` change reaches `gnt_o` two edges later. With 1 (asynchronous), they pass two registers, so the change takes three edges. The command register resets to 8'h02 and reads back.
- R10: `eop_o` is the active-high sampled form of `eop_n_i`, with the latency selected by R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dreq_i | input | 2 | Hardware request pins, channels 1:0 |
| eop_n_i | input | 1 | Active-low end-of-process pin |
| ext_req_i | input | 1 | External bus master request |
| tc_i | input | 2 | Terminal-count strobes, channels 1:0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| gnt_o | output | 3 | One-hot grant: ext, ch1, ch0 |
| eop_o | output | 1 | Sampled end-of-process, active high |

## Verification
A wrong mask, priority or software-request state shows on `gnt_o` one edge after the registered request set changes, because the grant register is the only stage between the two. A wrong sampling mode shows as `gnt_o` and `eop_o` moving one edge early or late relative to a pin change. A lost or stuck terminal-count flag shows on the next status read, and a wrongly cleared flag shows on the read after that. Hold faults surface only when a higher-priority request arrives during a grant, so those sequences are driven on purpose.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH  = 2;
  localparam int NREQ = NCH + 1;
  localparam int AW   = 3;
  localparam int DW   = 8;
  localparam int LOW_W = 2;

  localparam logic [AW-1:0] A_STAT  = 3'd0;
  localparam logic [AW-1:0] A_SWREQ = 3'd1;
  localparam logic [AW-1:0] A_CMASK = 3'd2;
  localparam logic [AW-1:0] A_GMASK = 3'd3;
  localparam logic [AW-1:0] A_CMD   = 3'd4;

  localparam int CMD_MODE_BIT = 4;
  localparam int STAT_TC_LSB  = 4;
  localparam logic [DW-1:0] CMD_RST = 8'h02;
endpackage

// File: rtl/dma_in_sampler.sv
module dma_in_sampler #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         async_mode,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] smp_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL[b];
        st2 <= RST_VAL[b];
      end else begin
        st1 <= pin_i[b];
        st2 <= st1;
      end
    end
    assign smp_o[b] = async_mode ? st2 : st1;
  end
endmodule

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NCH-1:0]   tc_i,
  input  logic [NCH-1:0]   hw_pend_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NCH-1:0]   swreq_o,
  output logic [NCH-1:0]   cmask_o,
  output logic             gmask_o,
  output logic [LOW_W-1:0] lowest_o,
  output logic             async_o
);
  logic [NCH-1:0] tc_seen;
  logic [DW-1:0]  cmd_q;
  logic           wr_sw, wr_cm, wr_gm, wr_cmd, rd_stat;

  assign wr_sw   = wr_i && (addr_i == A_SWREQ);
  assign wr_cm   = wr_i && (addr_i == A_CMASK);
  assign wr_gm   = wr_i && (addr_i == A_GMASK);
  assign wr_cmd  = wr_i && (addr_i == A_CMD);
  assign rd_stat = rd_i && (addr_i == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swreq_o <= '0;
      cmask_o <= '1;
      gmask_o <= 1'b0;
      cmd_q   <= CMD_RST;
      tc_seen <= '0;
    end else begin
      swreq_o <= (swreq_o | (wr_sw ? wdata_i[NCH-1:0] : '0)) & ~tc_i;
      if (wr_cm)  cmask_o <= wdata_i[NCH-1:0];
      if (wr_gm)  gmask_o <= wdata_i[0];
      if (wr_cmd) cmd_q   <= wdata_i;
      tc_seen <= (rd_stat ? '0 : tc_seen) | tc_i;
    end
  end

  assign lowest_o = cmd_q[LOW_W-1:0];
  assign async_o  = cmd_q[CMD_MODE_BIT];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_STAT: begin
          rdata_o[NCH-1:0]             = hw_pend_i;
          rdata_o[STAT_TC_LSB +: NCH]  = tc_seen;
        end
        A_SWREQ: rdata_o[NCH-1:0] = swreq_o;
        A_CMASK: rdata_o[NCH-1:0] = cmask_o;
        A_GMASK: rdata_o[0]       = gmask_o;
        A_CMD:   rdata_o          = cmd_q;
        default: rdata_o          = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  input  logic [LOW_W-1:0] lowest_i,
  output logic [NREQ-1:0]  gnt_o
);
  logic [LOW_W-1:0] low_idx;
  logic [NREQ-1:0]  pick, gnt_d;
  logic             found, hold;

  assign low_idx = (lowest_i >= LOW_W'(NREQ)) ? LOW_W'(NREQ - 1) : lowest_i;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (!found && (i != int'(low_idx)) && req_i[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found && req_i[low_idx]) pick[low_idx] = 1'b1;
  end

  assign hold  = |(gnt_o & req_i);
  assign gnt_d = hold ? gnt_o : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_o <= '0;
    else        gnt_o <= gnt_d;
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  dreq_i,
  input  logic            eop_n_i,
  input  logic            ext_req_i,
  input  logic [NCH-1:0]  tc_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [NREQ-1:0] gnt_o,
  output logic            eop_o
);
  logic [NCH-1:0]   swreq, cmask, hw_smp, hw_eff;
  logic             gmask, async_mode, ext_q, eop_n_smp;
  logic [LOW_W-1:0] lowest_sel;
  logic [NREQ-1:0]  req_all;

  dma_in_sampler #(
    .W       (NCH + 1),
    .RST_VAL ({1'b1, {NCH{1'b0}}})
  ) u_smp (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_mode (async_mode),
    .pin_i      ({eop_n_i, dreq_i}),
    .smp_o      ({eop_n_smp, hw_smp})
  );

  dma_arb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .tc_i      (tc_i),
    .hw_pend_i (hw_smp),
    .rdata_o   (reg_rdata_o),
    .swreq_o   (swreq),
    .cmask_o   (cmask),
    .gmask_o   (gmask),
    .lowest_o  (lowest_sel),
    .async_o   (async_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_req_i;
  end

  assign hw_eff  = hw_smp & ~cmask & ~{NCH{gmask}};
  assign req_all = {ext_q, hw_eff | swreq};
  assign eop_o   = ~eop_n_smp;

  dma_prio_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_all),
    .lowest_i (lowest_sel),
    .gnt_o    (gnt_o)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk
  import dma_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  gnt_o,
  input logic [NREQ-1:0]  req_all,
  input logic [NCH-1:0]   swreq,
  input logic [NCH-1:0]   tc_i,
  input logic [LOW_W-1:0] lowest_sel
);
  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt_o & req_all)) |=> (gnt_o == $past(gnt_o)));

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o == '0) && (|req_all)) |=> (gnt_o != '0));

  // R2
  ch0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o == '0) && req_all[0] && (lowest_sel != '0)) |=> gnt_o[0]);

  // R6
  sw_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o == '0) && swreq[1] && !req_all[0] && (lowest_sel != 2'd1))
      |=> gnt_o[1]);

  // R7
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_i[0] |=> !swreq[0]);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gnt_o      (gnt_o),
  .req_all    (req_all),
  .swreq      (swreq),
  .tc_i       (tc_i),
  .lowest_sel (lowest_sel)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] dreq_i = '0;
  logic       eop_n_i = 1'b1;
  logic       ext_req_i = 1'b0;
  logic [1:0] tc_i = '0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [2:0] gnt_o;
  logic       eop_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_arbiter dut (.*);

  localparam logic [2:0] STAT = 3'd0, SWR = 3'd1, CMK = 3'd2, GMK = 3'd3, CMD = 3'd4;

  // {lowest[1:0], sw[1:0], ext, expected grant[2:0]}
  localparam logic [7:0] VEC [8] = '{
    {2'd2, 2'b11, 1'b1, 3'b001},
    {2'd0, 2'b11, 1'b1, 3'b010},
    {2'd0, 2'b01, 1'b1, 3'b100},
    {2'd1, 2'b11, 1'b1, 3'b001},
    {2'd1, 2'b10, 1'b1, 3'b100},
    {2'd2, 2'b10, 1'b1, 3'b010},
    {2'd0, 2'b01, 1'b0, 3'b001},
    {2'd3, 2'b00, 1'b1, 3'b100}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tc_pulse(input logic [1:0] m);
    @(negedge clk); tc_i = m;
    @(negedge clk); tc_i = '0;
  endtask

  initial begin
    logic [7:0] r;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // reset state
    chk("R1 reset grant", {5'd0, gnt_o}, 8'h00);
    chk("R10 reset eop", {7'd0, eop_o}, 8'h00);
    rd(STAT, r); chk("R8 reset status", r, 8'h00);
    rd(SWR, r);  chk("R7 reset swreq", r, 8'h00);
    rd(CMK, r);  chk("R4 reset chmask", r, 8'h03);
    rd(GMK, r);  chk("R5 reset group", r, 8'h00);
    rd(CMD, r);  chk("R9 reset cmd", r, 8'h02);

    // priority table, R2 / R6
    for (int k = 0; k < 8; k++) begin
      wr(CMD, {6'd0, VEC[k][7:6]});
      @(negedge clk);
      ext_req_i = VEC[k][3];
      reg_wr_i = 1'b1; reg_addr_i = SWR; reg_wdata_i = {6'd0, VEC[k][5:4]};
      @(negedge clk);
      reg_wr_i = 1'b0;
      @(negedge clk);
      chk($sformatf("R2 priority vector %0d", k), {5'd0, gnt_o}, {5'd0, VEC[k][2:0]});
      ext_req_i = 1'b0;
      tc_pulse(2'b11);
      idle(2);
      chk($sformatf("R1 released vector %0d", k), {5'd0, gnt_o}, 8'h00);
    end

    // terminal-count flags and read-clear
    rd(STAT, r); chk("R8 tc latched", r, 8'h30);
    rd(STAT, r); chk("R8 tc cleared by read", r, 8'h00);

    // channel mask
    wr(CMD, 8'h02);
    @(negedge clk); dreq_i = 2'b01;
    idle(4);
    chk("R4 masked hw blocked", {5'd0, gnt_o}, 8'h00);
    rd(STAT, r); chk("R8 raw hw pending", r, 8'h01);
    wr(CMK, 8'h00);
    @(negedge clk);
    chk("R4 unmasked grant", {5'd0, gnt_o}, 8'h01);
    dreq_i = 2'b00;
    idle(3);

    // sampling latency, sync then async
    @(negedge clk); dreq_i = 2'b10;
    @(negedge clk); chk("R9 sync one edge", {5'd0, gnt_o}, 8'h00);
    @(negedge clk); chk("R9 sync two edges", {5'd0, gnt_o}, 8'h02);
    dreq_i = 2'b00;
    idle(3);
    wr(CMD, 8'h12);
    @(negedge clk); dreq_i = 2'b10;
    @(negedge clk); chk("R9 async one edge", {5'd0, gnt_o}, 8'h00);
    @(negedge clk); chk("R9 async two edges", {5'd0, gnt_o}, 8'h00);
    @(negedge clk); chk("R9 async three edges", {5'd0, gnt_o}, 8'h02);
    dreq_i = 2'b00;
    idle(4);
    @(negedge clk); eop_n_i = 1'b0;
    @(negedge clk); chk("R10 async eop one edge", {7'd0, eop_o}, 8'h00);
    @(negedge clk); chk("R10 async eop two edges", {7'd0, eop_o}, 8'h01);
    eop_n_i = 1'b1;
    idle(3);
    wr(CMD, 8'h02);

    // group mask and software override
    wr(GMK, 8'h01);
    rd(GMK, r); chk("R5 group readback", r, 8'h01);
    @(negedge clk); dreq_i = 2'b11;
    idle(4);
    chk("R5 group blocks both", {5'd0, gnt_o}, 8'h00);
    wr(SWR, 8'h01);
    @(negedge clk);
    chk("R6 sw passes group mask", {5'd0, gnt_o}, 8'h01);
    rd(SWR, r); chk("R7 sw pending", r, 8'h01);
    tc_pulse(2'b01);
    @(negedge clk);
    chk("R7 tc drops sw grant", {5'd0, gnt_o}, 8'h00);
    rd(SWR, r); chk("R7 sw cleared by tc", r, 8'h00);

    // grant hold
    @(negedge clk); dreq_i = 2'b10;
    idle(2);
    wr(GMK, 8'h00);
    @(negedge clk);
    chk("R3 ch1 granted", {5'd0, gnt_o}, 8'h02);
    wr(SWR, 8'h01);
    @(negedge clk);
    chk("R3 held against ch0", {5'd0, gnt_o}, 8'h02);
    dreq_i = 2'b00;
    @(negedge clk); chk("R3 still held one edge", {5'd0, gnt_o}, 8'h02);
    @(negedge clk); chk("R3 rearbitrated to ch0", {5'd0, gnt_o}, 8'h01);
    tc_pulse(2'b01);
    idle(2);

    // eop sampling, sync
    @(negedge clk); eop_n_i = 1'b0;
    @(negedge clk); chk("R10 eop asserted", {7'd0, eop_o}, 8'h01);
    eop_n_i = 1'b1;
    @(negedge clk); chk("R10 eop released", {7'd0, eop_o}, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule